// File: doc/BRIEF.md
# Ethernet PAUSE Flow Control Unit

This unit sits beside a MAC and applies IEEE 802.3x PAUSE flow control in both directions. On the receive side it takes PAUSE events that have already been decoded, each carrying a 16-bit TIME value. It loads a hold timer from that value. While the timer is non-zero it refuses grants to the transmitter's frame-start requests. The timer counts down by one on each pause-quantum tick. One quantum is 512 bit times, and the MAC supplies the tick. A frame already granted is never cut short, because the unit gates only the start of a frame. Every PAUSE event is counted in a saturating counter, which a strobe can clear.

On the transmit side the MAC reports each non-zero PAUSE it has sent to its link partner. That report opens an advertised window, which lasts the advertised number of quanta. If the local receive FIFO drains below a programmable threshold while that window is still open, the unit asks the frame generator for a zero-time PAUSE. The peer can then resume sending early. This request and the early release on a received zero-time PAUSE are both gated by their own enable.

Top module: `pause_flow_ctrl`

## Requirements
- R1: `tx_start_gnt` equals `tx_start_req` while `tx_paused` is low and is 0 while `tx_paused` is high; nothing else gates a grant.
- R2: An `rx_pause_vld` pulse with `rx_pause_en`=1 and a non-zero TIME of N raises `tx_paused` in the next cycle. `tx_paused` stays high through N-1 `quanta_tick` pulses and falls in the cycle after the Nth.
- R3: With `rx_pause_en`=0, a received PAUSE of any TIME leaves `tx_paused` unchanged.
- R4: A non-zero PAUSE received while paused reloads the hold timer with the new TIME and discards the remaining count.
- R5: With `rx_pause_en`=1 and `zero_pause_en`=1, a received PAUSE with TIME=0 drops `tx_paused` in the next cycle.
- R6: With `zero_pause_en`=0, a received PAUSE with TIME=0 is discarded, and the running hold count goes on unchanged.
- R7: `pause_cnt` goes up by one in the cycle after every `rx_pause_vld` pulse, whatever the enables and the TIME value. It holds at its maximum value and does not wrap.
- R8: `cnt_clr` sets `pause_cnt` to 0 in the next cycle and takes priority over a PAUSE event in the same cycle.
- R9: With `zero_pause_en`=1, while an advertised window is open and `rxq_level` < `rxq_thresh`, `zp_req` rises in the next cycle. It then stays high until the cycle after `zp_ack`.
- R10: Only one zero-time request is made per advertised window. After it is acknowledged, no further request is made until a new `adv_pause_vld` opens a new window.
- R11: With `zero_pause_en`=0, `zp_req` never rises.
- R12: After the advertised window has counted down to zero on `quanta_tick`, a low FIFO level raises no request.
- R13: After reset, `tx_paused`=0, `zp_req`=0 and `pause_cnt`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_pause_vld | input | 1 | One-cycle strobe: a PAUSE frame was received |
| rx_pause_time | input | 16 | TIME value of the received PAUSE, in quanta |
| rx_pause_en | input | 1 | Act on received PAUSE frames |
| zero_pause_en | input | 1 | Enable zero-time PAUSE, both sent and received |
| quanta_tick | input | 1 | One pulse per 512 bit times |
| adv_pause_vld | input | 1 | Strobe: local MAC sent a PAUSE to the peer |
| adv_pause_time | input | 16 | TIME value the local MAC advertised |
| tx_start_req | input | 1 | Transmitter asks to start a frame |
| tx_start_gnt | output | 1 | Frame start allowed |
| tx_paused | output | 1 | Hold timer is running |
| rxq_level | input | 12 | Receive FIFO occupancy |
| rxq_thresh | input | 12 | Drain threshold for zero-time PAUSE |
| zp_req | output | 1 | Request a zero-time PAUSE from the frame generator |
| zp_ack | input | 1 | Frame generator accepted the request |
| cnt_clr | input | 1 | Clear the reception counter |
| pause_cnt | output | 16 | Saturating count of received PAUSE frames |

## Verification
The bench builds the counter narrow, so that saturation is reached. A design that wrapped would show a small count after twenty frames. The bench checks the hold count one tick before and one tick after expiry, so a timer off by one shows up as a grant that comes one quantum early or late. A reload in the middle of a pause and a zero-time frame with its enable off are both driven. A design that kept the old count, or let the discarded frame clear the pause, would grant too soon. On the transmit side the bench holds the FIFO low across an acknowledged request, which catches a design that asks twice in one window. It also lets the window expire before the FIFO drains, which catches a design that asks outside the window.

// File: rtl/pause_flow_ctrl.sv
module pause_flow_ctrl #(
  parameter int TIME_W = 16,
  parameter int CNT_W  = 16,
  parameter int LVL_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_pause_vld,
  input  logic [TIME_W-1:0] rx_pause_time,
  input  logic              rx_pause_en,
  input  logic              zero_pause_en,
  input  logic              quanta_tick,
  input  logic              adv_pause_vld,
  input  logic [TIME_W-1:0] adv_pause_time,
  input  logic              tx_start_req,
  output logic              tx_start_gnt,
  output logic              tx_paused,
  input  logic [LVL_W-1:0]  rxq_level,
  input  logic [LVL_W-1:0]  rxq_thresh,
  output logic              zp_req,
  input  logic              zp_ack,
  input  logic              cnt_clr,
  output logic [CNT_W-1:0]  pause_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [TIME_W-1:0] hold_q, win_q;
  logic              zp_used_q, zp_req_q;
  logic [CNT_W-1:0]  cnt_q;

  logic rx_take, rx_zero, win_open, zp_fire;

  assign rx_take  = rx_pause_vld & rx_pause_en;
  assign rx_zero  = (rx_pause_time == '0);
  assign win_open = (win_q != '0);
  assign zp_fire  = zero_pause_en & win_open & (rxq_level < rxq_thresh)
                  & ~zp_used_q & ~zp_req_q & ~adv_pause_vld;

  always_ff @(posedge clk) begin
    if (!rst_n)
      hold_q <= '0;
    else if (rx_take && !rx_zero)
      hold_q <= rx_pause_time;
    else if (rx_take && zero_pause_en)
      hold_q <= '0;
    else if (quanta_tick && hold_q != '0)
      hold_q <= hold_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      win_q <= '0;
    else if (adv_pause_vld)
      win_q <= adv_pause_time;
    else if (zp_req_q && zp_ack)
      win_q <= '0;
    else if (quanta_tick && win_open)
      win_q <= win_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      zp_used_q <= 1'b0;
      zp_req_q  <= 1'b0;
    end else begin
      if (adv_pause_vld)
        zp_used_q <= 1'b0;
      else if (zp_fire)
        zp_used_q <= 1'b1;
      if (zp_fire)
        zp_req_q <= 1'b1;
      else if (zp_ack)
        zp_req_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || cnt_clr)
      cnt_q <= '0;
    else if (rx_pause_vld && cnt_q != CNT_MAX)
      cnt_q <= cnt_q + 1'b1;
  end

  assign tx_paused    = (hold_q != '0);
  assign tx_start_gnt = tx_start_req & ~tx_paused;
  assign zp_req       = zp_req_q;
  assign pause_cnt    = cnt_q;
endmodule

module pause_flow_ctrl_chk #(
  parameter int TIME_W = 16,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_pause_vld,
  input logic [TIME_W-1:0] rx_pause_time,
  input logic              rx_pause_en,
  input logic              zero_pause_en,
  input logic              tx_start_gnt,
  input logic              tx_paused,
  input logic              zp_req,
  input logic              zp_ack,
  input logic              cnt_clr,
  input logic [CNT_W-1:0]  pause_cnt
);
  // R1
  gnt_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_paused |-> !tx_start_gnt);
  // R2
  pause_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pause_vld && rx_pause_en && rx_pause_time != '0) |=> tx_paused);
  // R3
  rx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pause_vld && !rx_pause_en && !tx_paused) |=> !tx_paused);
  // R5
  zero_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pause_vld && rx_pause_en && zero_pause_en && rx_pause_time == '0) |=> !tx_paused);
  // R8
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (pause_cnt == '0));
  // R7
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_cnt == '1 && !cnt_clr) |=> (pause_cnt == '1));
  // R9
  zp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (zp_req && !zp_ack) |=> zp_req);
  // R11
  zp_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!zero_pause_en && !zp_req) |=> !zp_req);
endmodule

bind pause_flow_ctrl pause_flow_ctrl_chk #(.TIME_W(TIME_W), .CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .rx_pause_vld(rx_pause_vld), .rx_pause_time(rx_pause_time),
  .rx_pause_en(rx_pause_en), .zero_pause_en(zero_pause_en), .tx_start_gnt(tx_start_gnt),
  .tx_paused(tx_paused), .zp_req(zp_req), .zp_ack(zp_ack), .cnt_clr(cnt_clr),
  .pause_cnt(pause_cnt));

// File: tb/test_pause_flow_ctrl.sv
`timescale 1ns/1ps
module test_pause_flow_ctrl;
  localparam int CW = 4;

  logic clk = 0, rst_n = 0;
  logic rx_pause_vld = 0, rx_pause_en = 0, zero_pause_en = 0, quanta_tick = 0;
  logic [15:0] rx_pause_time = '0, adv_pause_time = '0;
  logic adv_pause_vld = 0, tx_start_req = 0, zp_ack = 0, cnt_clr = 0;
  logic [11:0] rxq_level = 12'd100, rxq_thresh = 12'd50;
  logic tx_start_gnt, tx_paused, zp_req;
  logic [CW-1:0] pause_cnt;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  pause_flow_ctrl #(.CNT_W(CW)) i_pause_flow_ctrl (
    .clk(clk), .rst_n(rst_n), .rx_pause_vld(rx_pause_vld), .rx_pause_time(rx_pause_time),
    .rx_pause_en(rx_pause_en), .zero_pause_en(zero_pause_en), .quanta_tick(quanta_tick),
    .adv_pause_vld(adv_pause_vld), .adv_pause_time(adv_pause_time),
    .tx_start_req(tx_start_req), .tx_start_gnt(tx_start_gnt), .tx_paused(tx_paused),
    .rxq_level(rxq_level), .rxq_thresh(rxq_thresh), .zp_req(zp_req), .zp_ack(zp_ack),
    .cnt_clr(cnt_clr), .pause_cnt(pause_cnt));

  task automatic step(); @(posedge clk); #1; endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(); rst_n = 0; step(); step(); rst_n = 1; endtask

  task automatic rx(logic en, logic [15:0] t);
    rx_pause_en = en; rx_pause_time = t; rx_pause_vld = 1; step(); rx_pause_vld = 0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin quanta_tick = 1; step(); quanta_tick = 0; end
  endtask

  task automatic adv(logic [15:0] t);
    adv_pause_time = t; adv_pause_vld = 1; step(); adv_pause_vld = 0;
  endtask

  // {rx_en, zero_en, time[15:0], ticks[7:0], exp_paused}
  localparam int NV = 8;
  localparam logic [26:0] VEC [NV] = '{
    {1'b1, 1'b1, 16'd3,     8'd2,  1'b1},
    {1'b1, 1'b1, 16'd3,     8'd3,  1'b0},
    {1'b0, 1'b1, 16'd5,     8'd0,  1'b0},
    {1'b1, 1'b0, 16'd1,     8'd0,  1'b1},
    {1'b1, 1'b0, 16'd1,     8'd1,  1'b0},
    {1'b1, 1'b1, 16'd0,     8'd0,  1'b0},
    {1'b1, 1'b0, 16'd0,     8'd0,  1'b0},
    {1'b1, 1'b1, 16'hFFFF,  8'd10, 1'b1}
  };

  initial begin
    #(4ns * 150000);
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset();
    tx_start_req = 1; #0.5;
    // R13 reset state
    chk("R13 paused", tx_paused, 0);
    chk("R13 zp_req", zp_req, 0);
    chk("R13 cnt", pause_cnt, 0);
    chk("R1 grant idle", tx_start_gnt, 1);

    for (int v = 0; v < NV; v++) begin
      do_reset();
      zero_pause_en = VEC[v][25];
      rx(VEC[v][26], VEC[v][24:9]);
      ticks(int'(VEC[v][8:1]));
      chk($sformatf("R2/R3/R6 vec%0d paused", v), tx_paused, VEC[v][0]);
      chk($sformatf("R1 vec%0d grant", v), tx_start_gnt, !VEC[v][0]);
    end

    // R4 reload
    do_reset(); zero_pause_en = 1;
    rx(1, 16'd2); ticks(1); rx(1, 16'd5); ticks(4);
    chk("R4 still paused", tx_paused, 1);
    ticks(1);
    chk("R4 released", tx_paused, 0);

    // R5 zero-time release
    do_reset(); zero_pause_en = 1;
    rx(1, 16'd10);
    chk("R5 paused", tx_paused, 1);
    rx(1, 16'd0);
    chk("R5 released", tx_paused, 0);

    // R6 zero-time discarded
    do_reset(); zero_pause_en = 0;
    rx(1, 16'd10); rx(1, 16'd0); ticks(9);
    chk("R6 still paused", tx_paused, 1);
    ticks(1);
    chk("R6 expired", tx_paused, 0);

    // R7 count and saturation
    do_reset();
    rx(0, 16'd4); rx(1, 16'd0); zero_pause_en = 1; rx(1, 16'd0);
    chk("R7 count", pause_cnt, 3);
    for (int i = 0; i < 20; i++) rx(0, 16'd1);
    chk("R7 saturate", pause_cnt, 15);

    // R8 clear and priority
    cnt_clr = 1; step(); cnt_clr = 0;
    chk("R8 cleared", pause_cnt, 0);
    rx(0, 16'd1); rx(0, 16'd1);
    cnt_clr = 1; rx_pause_vld = 1; step(); cnt_clr = 0; rx_pause_vld = 0;
    chk("R8 clear wins", pause_cnt, 0);

    // R9 request and hold
    do_reset(); zero_pause_en = 1; rxq_level = 12'd100;
    adv(16'd20); step();
    chk("R9 no req above thresh", zp_req, 0);
    rxq_level = 12'd10; step();
    chk("R9 req raised", zp_req, 1);
    step(); step();
    chk("R9 req held", zp_req, 1);
    zp_ack = 1; step(); zp_ack = 0;
    chk("R9 req dropped", zp_req, 0);

    // R10 once per window
    step(); step();
    chk("R10 no second req", zp_req, 0);
    adv(16'd20); step();
    chk("R10 new window req", zp_req, 1);
    zp_ack = 1; step(); zp_ack = 0;

    // R11 disabled
    do_reset(); zero_pause_en = 0; rxq_level = 12'd10;
    adv(16'd20); step(); step();
    chk("R11 no req", zp_req, 0);

    // R12 window expired
    do_reset(); zero_pause_en = 1; rxq_level = 12'd100;
    adv(16'd2); ticks(2); rxq_level = 12'd10; step(); step();
    chk("R12 no req after window", zp_req, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule